// File: doc/BRIEF.md
# Receive FIFO with Character Timeout

This block is the receive-side buffer of a 16550-style serial channel. A deserializer hands it one character per frame, with a single-cycle strobe at the centre of that frame's stop bit. Characters go into a 16-entry first-in first-out store. The host drains the store one byte at a time through a holding-register read. Two interrupt outputs tell the host when to come back for data. `irq_data` rises when the fill level reaches a programmable threshold. `irq_timeout` rises when bytes have waited unread for four character times.

The timeout is counted in half-bit ticks. One tick is supplied by the baud logic every half bit period, so frames with one and a half stop bits are timed exactly. A small state machine guards the timeout and has three states:

- `TO_IDLE`: nothing is buffered, or FIFO mode is off.
- `TO_RUN`: counting ticks.
- `TO_FIRED`: the interrupt is pending.

The machine has the following transitions:

- IDLE→RUN when a byte is stored in FIFO mode.
- RUN→RUN, with the counter restarted, on a stored byte or a host read.
- RUN→FIRED when the tick count reaches the limit.
- FIRED→RUN on a host read that leaves data behind.
- RUN/FIRED→IDLE when the store is about to become empty or FIFO mode is turned off.

With FIFO mode off, the store acts as a one-byte holding register.

Top module: `rx_fifo_timeout`

## Requirements
- R1: After reset the level is 0, and `data_ready`, `irq_data`, `irq_timeout` and `overrun` are all low.
- R2: With `fifo_en`=1 the store holds up to 16 bytes and returns them in arrival order on `rd_data`. `rd_data` shows the oldest byte, and each `rd_req` pulse removes it.
- R3: A character strobed into a full store, with no read in the same cycle, is dropped and sets `overrun`. `overrun` clears on the next `rd_req`.
- R4: `trig_sel` encodes the threshold as 00→1, 01→4, 10→8, 11→14. `irq_data` is high while level ≥ threshold, and it stays high as the store fills past it.
- R5: With `fifo_en`=0 the capacity is one byte and the threshold is 1. A second byte before a read is an overrun, and `irq_timeout` never asserts.
- R6: `data_ready` is high exactly when at least one byte is stored. It falls only after the read of the last byte.
- R7: The timeout limit, in `half_tick` pulses, is 4·(2·(1+N+P)+S). Here N=5+`data_bits`, P=`parity_en`, and S is 2 for one stop bit. When `stop_two`=1, S is 3 if N=5 and 4 otherwise. `irq_timeout` rises on the pulse that reaches the limit.
- R8: Each stored character and each host read restarts the tick count from zero.
- R9: `irq_timeout` is never high while the store is empty, whatever the number of ticks.
- R10: A host read clears `irq_timeout` in the next cycle. If data remains, counting begins again.
- R11: Any change of `fifo_en` empties the store on the following clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1 = 16-byte FIFO mode, 0 = single holding register |
| trig_sel | input | 2 | Receive threshold select |
| data_bits | input | 2 | Data length minus 5 |
| parity_en | input | 1 | Parity bit present in frame |
| stop_two | input | 1 | Long stop (1.5 bits for 5-bit data, else 2) |
| half_tick | input | 1 | One pulse per half bit period |
| rx_push | input | 1 | Stop-bit centre strobe carrying a character |
| rx_data | input | 8 | Received character |
| rd_req | input | 1 | Host read of the holding register |
| rd_data | output | 8 | Oldest stored byte |
| rx_level | output | 5 | Bytes stored |
| data_ready | output | 1 | At least one byte stored |
| irq_data | output | 1 | Level reached threshold |
| irq_timeout | output | 1 | Character timeout pending |
| overrun | output | 1 | A character was dropped |

## Verification
The hardest situation to reach is a restart landing in the middle of a count, followed by an exact expiry. A late character must push the expiry back by a full limit, rather than only by the ticks that remain. The stimulus first delivers part of a limit's worth of ticks, then strobes another character. It then delivers exactly one tick fewer than the limit and checks that nothing has fired, then one more tick and checks that it has. The 1.5-stop format is used so that the odd half-bit count is exercised. A host read that leaves a byte behind is then used to show that counting starts again from zero.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic [1:0] {
        TO_IDLE,
        TO_RUN,
        TO_FIRED
    } to_state_t;

    // Four character times in half-bit ticks for the given frame format.
    function automatic logic [6:0] timeout_halves(
        input logic [1:0] data_len,
        input logic       par_on,
        input logic       long_stop
    );
        logic [4:0] bits;
        logic [4:0] halves;
        bits   = 5'd6 + {3'b000, data_len} + {4'b0000, par_on};
        halves = {bits[3:0], 1'b0};
        if (!long_stop)
            halves = halves + 5'd2;
        else if (data_len == 2'd0)
            halves = halves + 5'd3;
        else
            halves = halves + 5'd4;
        return {halves, 2'b00};
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter  int DEPTH = 16,
    parameter  int W     = 8,
    localparam int PW    = $clog2(DEPTH),
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          single,
    input  logic          push,
    input  logic          rd,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    output logic [LW-1:0] level,
    output logic          empty_nxt,
    output logic          accept,
    output logic          pop,
    output logic          overrun
);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic [LW-1:0] cap;
    logic [LW-1:0] lvl_nxt;
    logic          full;

    assign cap       = single ? LW'(1) : LW'(DEPTH);
    assign full      = level >= cap;
    assign pop       = rd && (level != '0) && !flush;
    assign accept    = push && !flush && (!full || pop);
    assign lvl_nxt   = flush ? '0 : level + LW'(accept) - LW'(pop);
    assign empty_nxt = (lvl_nxt == '0);
    assign rdata     = mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            level   <= '0;
            overrun <= 1'b0;
        end else if (flush) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            level   <= '0;
            overrun <= 1'b0;
        end else begin
            if (accept) wr_ptr <= wr_ptr + PW'(1);
            if (pop)    rd_ptr <= rd_ptr + PW'(1);
            level <= lvl_nxt;
            if (push && !accept)
                overrun <= 1'b1;
            else if (rd)
                overrun <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (accept) mem[wr_ptr] <= wdata;
    end

    // R2: the level never exceeds the storage depth
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));

    // R3: a dropped character raises the overrun flag
    p_overrun_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !rd && !flush) |=> overrun);

endmodule

// File: rtl/rxq_timer.sv
module rxq_timer
    import rxq_pkg::*;
#(
    parameter int TW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          empty_nxt,
    input  logic          push_ok,
    input  logic          pop,
    input  logic          half_tick,
    input  logic [TW-1:0] limit,
    output logic          fired
);

    to_state_t     state, state_nxt;
    logic [TW-1:0] count, count_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TO_IDLE;
            count <= '0;
        end else begin
            state <= state_nxt;
            count <= count_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        count_nxt = count;
        unique case (state)
            TO_IDLE: begin
                count_nxt = '0;
                if (enable && !empty_nxt)
                    state_nxt = TO_RUN;
            end
            TO_RUN: begin
                if (!enable || empty_nxt) begin
                    state_nxt = TO_IDLE;
                    count_nxt = '0;
                end else if (push_ok || pop) begin
                    count_nxt = '0;
                end else if (half_tick) begin
                    if (count == limit - TW'(1)) begin
                        state_nxt = TO_FIRED;
                        count_nxt = '0;
                    end else begin
                        count_nxt = count + TW'(1);
                    end
                end
            end
            TO_FIRED: begin
                count_nxt = '0;
                if (!enable || empty_nxt)
                    state_nxt = TO_IDLE;
                else if (pop)
                    state_nxt = TO_RUN;
            end
            default: begin
                state_nxt = TO_IDLE;
                count_nxt = '0;
            end
        endcase
    end

    always_comb fired = (state == TO_FIRED);

    // R10: a host read removes a pending timeout
    p_clear_on_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fired && pop) |=> !fired);

    // R5: no timeout while FIFO mode is off
    p_no_timeout_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !fired);

    // R9: a pending timeout never follows the store becoming empty
    p_no_timeout_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        empty_nxt |=> !fired);

endmodule

// File: rtl/rx_fifo_timeout.sv
module rx_fifo_timeout
    import rxq_pkg::*;
#(
    parameter  int DEPTH = 16,
    parameter  int W     = 8,
    parameter  int TW    = 7,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic [1:0]    trig_sel,
    input  logic [1:0]    data_bits,
    input  logic          parity_en,
    input  logic          stop_two,
    input  logic          half_tick,
    input  logic          rx_push,
    input  logic [W-1:0]  rx_data,
    input  logic          rd_req,
    output logic [W-1:0]  rd_data,
    output logic [LW-1:0] rx_level,
    output logic          data_ready,
    output logic          irq_data,
    output logic          irq_timeout,
    output logic          overrun
);

    logic          mode_q;
    logic          flush;
    logic          empty_nxt;
    logic          accept;
    logic          pop;
    logic [LW-1:0] trig;
    logic [TW-1:0] limit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= 1'b0;
        else        mode_q <= fifo_en;
    end

    assign flush = (fifo_en != mode_q);
    assign limit = TW'(timeout_halves(data_bits, parity_en, stop_two));

    always_comb begin
        if (!fifo_en) begin
            trig = LW'(1);
        end else begin
            unique case (trig_sel)
                2'd0: trig = LW'(1);
                2'd1: trig = LW'(4);
                2'd2: trig = LW'(8);
                2'd3: trig = LW'(14);
                default: trig = LW'(1);
            endcase
        end
    end

    rxq_store #(.DEPTH(DEPTH), .W(W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .single    (!fifo_en),
        .push      (rx_push),
        .rd        (rd_req),
        .wdata     (rx_data),
        .rdata     (rd_data),
        .level     (rx_level),
        .empty_nxt (empty_nxt),
        .accept    (accept),
        .pop       (pop),
        .overrun   (overrun)
    );

    rxq_timer #(.TW(TW)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (fifo_en),
        .empty_nxt (empty_nxt),
        .push_ok   (accept),
        .pop       (pop),
        .half_tick (half_tick),
        .limit     (limit),
        .fired     (irq_timeout)
    );

    assign data_ready = (rx_level != '0);
    assign irq_data   = (rx_level >= trig);

    // R6: data_ready only falls after a read or a mode-change flush
    p_ready_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_ready) |-> ($past(rd_req) || $past(flush)));

endmodule

// File: tb/test_rx_fifo_timeout.sv
`timescale 1ns/1ps
module test_rx_fifo_timeout;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b0;
    logic [1:0] trig_sel = 2'd0;
    logic [1:0] data_bits = 2'd3;
    logic       parity_en = 1'b0;
    logic       stop_two = 1'b0;
    logic       half_tick = 1'b0;
    logic       rx_push = 1'b0;
    logic [7:0] rx_data = 8'd0;
    logic       rd_req = 1'b0;
    logic [7:0] rd_data;
    logic [4:0] rx_level;
    logic       data_ready, irq_data, irq_timeout, overrun;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [7:0] sb[$];

    always #2.5 clk = ~clk;

    rx_fifo_timeout i_rx_fifo_timeout (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .trig_sel(trig_sel),
        .data_bits(data_bits), .parity_en(parity_en), .stop_two(stop_two),
        .half_tick(half_tick), .rx_push(rx_push), .rx_data(rx_data),
        .rd_req(rd_req), .rd_data(rd_data), .rx_level(rx_level),
        .data_ready(data_ready), .irq_data(irq_data),
        .irq_timeout(irq_timeout), .overrun(overrun)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    // driver: strobe one character and record it in the scoreboard if it fits
    task automatic push_byte(input logic [7:0] d);
        rx_push = 1'b1;
        rx_data = d;
        cyc();
        rx_push = 1'b0;
        if (sb.size() < (fifo_en ? 16 : 1)) sb.push_back(d);
    endtask

    // monitor: compare the head against the scoreboard, then read it
    task automatic read_byte(input string req);
        if (sb.size() != 0) chk(req, int'(rd_data), int'(sb.pop_front()));
        rd_req = 1'b1;
        cyc();
        rd_req = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            half_tick = 1'b1;
            cyc();
            half_tick = 1'b0;
            cyc();
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R1: reset state
        chk("R1 level", rx_level, 0);
        chk("R1 ready", data_ready, 0);
        chk("R1 irqs", {irq_data, irq_timeout, overrun}, 0);

        fifo_en  = 1'b1;
        trig_sel = 2'd2;
        cyc(); cyc();
        for (int i = 0; i < 7; i++) push_byte(8'h10 + 8'(i));
        chk("R4 below threshold 8", irq_data, 0);
        push_byte(8'h17);
        chk("R4 at threshold 8", irq_data, 1);
        for (int i = 8; i < 16; i++) push_byte(8'h10 + 8'(i));
        chk("R4 held past threshold", irq_data, 1);
        chk("R2 level full", rx_level, 16);
        chk("R3 no overrun yet", overrun, 0);
        push_byte(8'hEE);
        chk("R3 overrun set", overrun, 1);
        chk("R3 level unchanged", rx_level, 16);
        read_byte("R2 order");
        chk("R3 overrun cleared", overrun, 0);
        while (sb.size() > 0) begin
            read_byte("R2 order");
            chk("R6 ready tracks level", data_ready, (sb.size() > 0) ? 1 : 0);
        end
        chk("R2 empty", rx_level, 0);

        trig_sel = 2'd1;
        for (int i = 0; i < 3; i++) push_byte(8'h30 + 8'(i));
        chk("R4 three below 4", irq_data, 0);
        push_byte(8'h33);
        chk("R4 four reaches 4", irq_data, 1);
        while (sb.size() > 0) read_byte("R2 order");

        // 8 data bits, no parity, 1 stop: 4*(2*9+2) = 80
        push_byte(8'hA5);
        tick(79);
        chk("R7 not yet 8N1", irq_timeout, 0);
        tick(1);
        chk("R7 fires at 80", irq_timeout, 1);
        read_byte("R2 order");
        chk("R10 cleared by read", irq_timeout, 0);
        tick(200);
        chk("R9 empty never times out", irq_timeout, 0);

        // 5 data bits, parity, 1.5 stop: 4*(2*7+3) = 68
        data_bits = 2'd0;
        parity_en = 1'b1;
        stop_two  = 1'b1;
        push_byte(8'h01);
        tick(40);
        push_byte(8'h02);
        tick(67);
        chk("R8 restart on push", irq_timeout, 0);
        tick(1);
        chk("R7 fires at 68", irq_timeout, 1);
        read_byte("R2 order");
        chk("R10 cleared with data left", irq_timeout, 0);
        tick(67);
        chk("R8 restart on read", irq_timeout, 0);
        tick(1);
        chk("R10 counts again", irq_timeout, 1);
        read_byte("R2 order");
        chk("R9 cleared on empty", irq_timeout, 0);

        // 7 data bits, 2 stop: 4*(2*8+4) = 80
        data_bits = 2'd2;
        parity_en = 1'b0;
        push_byte(8'h55);
        tick(79);
        chk("R7 not yet 7N2", irq_timeout, 0);
        tick(1);
        chk("R7 fires 7N2", irq_timeout, 1);

        // mode change flush, then holding-register mode
        push_byte(8'h56);
        fifo_en = 1'b0;
        cyc();
        sb.delete();
        cyc();
        chk("R11 flushed", rx_level, 0);
        chk("R5 timeout off", irq_timeout, 0);
        trig_sel = 2'd3;
        push_byte(8'h77);
        chk("R5 trigger is 1", irq_data, 1);
        push_byte(8'h78);
        chk("R5 one-byte overrun", overrun, 1);
        chk("R5 level one", rx_level, 1);
        tick(300);
        chk("R5 no timeout", irq_timeout, 0);
        read_byte("R5 holds first");
        chk("R6 ready low", data_ready, 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule